// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches a set of independent power domains on and off. Each domain has three control lines: a power-switch line, an active-low reset and an active-low isolation enable. A single command port takes a request to turn one domain up or down. The controller then steps through that domain's control lines in a fixed order, waiting a parameterised number of clock cycles between steps. Only one sequence runs at a time. A request that arrives while a sequence is in progress is refused and sets a sticky error flag.

Each domain can be built with or without a reset line and with or without an isolation line. A missing line's step is skipped in one cycle and drives nothing. A domain can also be built to use an extended power-up order. That order releases isolation early, emits one-cycle strobes for memory repair and for the memory, bus and module clock enables, and releases reset last. The strobes only model those actions. The analog switches, the repair logic and the clock gates sit outside this block.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset, every domain whose bit in INIT_OFF is 1 has `pwr_off`=1, `dom_rst_n`=0 and `iso_n`=0. Every other domain has `pwr_off`=0, `dom_rst_n`=1 and `iso_n`=1. A domain built without isolation keeps `iso_n`=1 and one built without reset keeps `dom_rst_n`=1. `busy`, `done` and `cmd_err` are 0.
- R2: A down command (`cmd_up`=0) first clears `iso_n` of the selected domain, then clears `dom_rst_n`, and last sets `pwr_off`. The lines of other domains do not change.
- R3: On a domain without the extended order, an up command (`cmd_up`=1) first clears `pwr_off`, then sets `dom_rst_n`, and last sets `iso_n`.
- R4: On a domain with the extended order, an up command does seven steps in this order: clear `pwr_off`, set `iso_n`, pulse `repair_stb`, pulse `sram_clk_stb`, pulse `bus_clk_stb`, pulse `mod_clk_stb`, set `dom_rst_n`. Each strobe is high for exactly one cycle.
- R5: A command is accepted on the clock edge at which `cmd_valid`=1 and `busy`=0. The first step takes effect on the next edge. Each later step comes STEP_DLY cycles after the step before it.
- R6: When a domain has no line for a step, that step changes no output and the next step follows one cycle later.
- R7: `busy` is 1 from the edge that accepts a command until the edge of the last step, where it returns to 0. `done` is 1 for the single cycle after that edge.
- R8: A command with `cmd_valid`=1 while `busy`=1 is ignored. It does not affect any domain and sets `cmd_err`, which stays 1 until reset.
- R9: `dom_on` of each domain is the inverse of its `pwr_off`, so a 1 in the power bit reads as off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_up | input | 1 | 1 = power up, 0 = power down |
| cmd_dom | input | DW | Index of the target domain |
| pwr_off | output | N_DOM | Power switch per domain, 1 = off |
| iso_n | output | N_DOM | Isolation per domain, 0 = isolated |
| dom_rst_n | output | N_DOM | Reset per domain, 0 = held in reset |
| repair_stb | output | N_DOM | Memory repair strobe |
| sram_clk_stb | output | N_DOM | Memory clock enable strobe |
| bus_clk_stb | output | N_DOM | Bus clock enable strobe |
| mod_clk_stb | output | N_DOM | Module clock enable strobe |
| dom_on | output | N_DOM | Domain powered status |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the last step |
| cmd_err | output | 1 | Sticky refused-command flag |

## Verification
The assertions assume that `cmd_dom` always names an existing domain. They also assume that commands are single-cycle pulses. The ordering checks rely on the lines changing only under control of the sequencer. The bench raises `cmd_valid` for one cycle with a legal index and sends every domain both an up and a down command. On purpose, it sends one extra command while a sequence is running.

// File: rtl/pds_pkg.sv
package pds_pkg;

   typedef enum logic [3:0] {
      ACT_NONE,
      ACT_ISO_ON,
      ACT_RST_ON,
      ACT_PWR_OFF,
      ACT_PWR_ON,
      ACT_RST_REL,
      ACT_ISO_REL,
      ACT_REPAIR,
      ACT_SRAM_CLK,
      ACT_BUS_CLK,
      ACT_MOD_CLK
   } pds_act_e;

   // Action performed at step idx of a sequence.
   function automatic pds_act_e step_act(input logic up, input logic late,
                                         input logic [2:0] idx);
      pds_act_e a;
      a = ACT_NONE;
      if (!up) begin
         case (idx)
            3'd0: a = ACT_ISO_ON;
            3'd1: a = ACT_RST_ON;
            3'd2: a = ACT_PWR_OFF;
            default: a = ACT_NONE;
         endcase
      end else if (!late) begin
         case (idx)
            3'd0: a = ACT_PWR_ON;
            3'd1: a = ACT_RST_REL;
            3'd2: a = ACT_ISO_REL;
            default: a = ACT_NONE;
         endcase
      end else begin
         case (idx)
            3'd0: a = ACT_PWR_ON;
            3'd1: a = ACT_ISO_REL;
            3'd2: a = ACT_REPAIR;
            3'd3: a = ACT_SRAM_CLK;
            3'd4: a = ACT_BUS_CLK;
            3'd5: a = ACT_MOD_CLK;
            3'd6: a = ACT_RST_REL;
            default: a = ACT_NONE;
         endcase
      end
      return a;
   endfunction

   function automatic logic [2:0] last_step(input logic up, input logic late);
      return (up && late) ? 3'd6 : 3'd2;
   endfunction

   function automatic logic is_iso_act(input pds_act_e a);
      return (a == ACT_ISO_ON) || (a == ACT_ISO_REL);
   endfunction

   function automatic logic is_rst_act(input pds_act_e a);
      return (a == ACT_RST_ON) || (a == ACT_RST_REL);
   endfunction

endpackage

// File: rtl/pds_sequencer.sv
module pds_sequencer
   import pds_pkg::*;
#(
   parameter int unsigned N_DOM       = 2,
   parameter int unsigned DW          = 1,
   parameter int unsigned STEP_DLY    = 4,
   parameter logic [N_DOM-1:0] ISO_PRESENT = '1,
   parameter logic [N_DOM-1:0] RST_PRESENT = '1,
   parameter logic [N_DOM-1:0] LATE_UP     = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic          cmd_up,
   input  logic [DW-1:0] cmd_dom,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic          fire,
   output pds_act_e      act,
   output logic [DW-1:0] act_dom
);

   localparam int unsigned CNT_W = (STEP_DLY > 1) ? $clog2(STEP_DLY) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STEP_DLY - 1);

   logic             busy_q, done_q, err_q, up_q;
   logic [DW-1:0]    dom_q;
   logic [2:0]       idx_q;
   logic [CNT_W-1:0] cnt_q;

   logic     late, absent, at_step;
   pds_act_e cur;

   always_comb begin
      late    = LATE_UP[dom_q];
      cur     = step_act(up_q, late, idx_q);
      absent  = (is_iso_act(cur) && !ISO_PRESENT[dom_q]) ||
                (is_rst_act(cur) && !RST_PRESENT[dom_q]);
      at_step = busy_q && (cnt_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         up_q   <= 1'b0;
         dom_q  <= '0;
         idx_q  <= '0;
         cnt_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (cmd_valid) begin
            if (busy_q) begin
               err_q <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               up_q   <= cmd_up;
               dom_q  <= cmd_dom;
               idx_q  <= '0;
               cnt_q  <= '0;
            end
         end
         if (at_step) begin
            if (idx_q == last_step(up_q, late)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 3'd1;
               cnt_q <= absent ? '0 : RELOAD;
            end
         end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign err     = err_q;
   assign fire    = at_step && !absent;
   assign act     = cur;
   assign act_dom = dom_q;

endmodule

// File: rtl/pds_dom_bank.sv
module pds_dom_bank
   import pds_pkg::*;
#(
   parameter int unsigned N_DOM       = 2,
   parameter int unsigned DW          = 1,
   parameter logic [N_DOM-1:0] ISO_PRESENT = '1,
   parameter logic [N_DOM-1:0] RST_PRESENT = '1,
   parameter logic [N_DOM-1:0] INIT_OFF    = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  pds_act_e         act,
   input  logic [DW-1:0]    act_dom,
   output logic [N_DOM-1:0] pwr_off,
   output logic [N_DOM-1:0] iso_n,
   output logic [N_DOM-1:0] rst_n_o,
   output logic [N_DOM-1:0] repair,
   output logic [N_DOM-1:0] sram_clk,
   output logic [N_DOM-1:0] bus_clk,
   output logic [N_DOM-1:0] mod_clk
);

   for (genvar i = 0; i < N_DOM; i++) begin : g_dom
      localparam logic ISO_RST = ISO_PRESENT[i] ? !INIT_OFF[i] : 1'b1;
      localparam logic RST_RST = RST_PRESENT[i] ? !INIT_OFF[i] : 1'b1;

      logic pwr_q, iso_q, rst_q, rep_q, sram_q, bus_q, mod_q;
      logic sel;

      assign sel = fire && (act_dom == DW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pwr_q  <= INIT_OFF[i];
            iso_q  <= ISO_RST;
            rst_q  <= RST_RST;
            rep_q  <= 1'b0;
            sram_q <= 1'b0;
            bus_q  <= 1'b0;
            mod_q  <= 1'b0;
         end else begin
            rep_q  <= sel && (act == ACT_REPAIR);
            sram_q <= sel && (act == ACT_SRAM_CLK);
            bus_q  <= sel && (act == ACT_BUS_CLK);
            mod_q  <= sel && (act == ACT_MOD_CLK);
            if (sel) begin
               case (act)
                  ACT_ISO_ON:  iso_q <= 1'b0;
                  ACT_ISO_REL: iso_q <= 1'b1;
                  ACT_RST_ON:  rst_q <= 1'b0;
                  ACT_RST_REL: rst_q <= 1'b1;
                  ACT_PWR_OFF: pwr_q <= 1'b1;
                  ACT_PWR_ON:  pwr_q <= 1'b0;
                  default: ;
               endcase
            end
         end
      end

      assign pwr_off[i]  = pwr_q;
      assign iso_n[i]    = iso_q;
      assign rst_n_o[i]  = rst_q;
      assign repair[i]   = rep_q;
      assign sram_clk[i] = sram_q;
      assign bus_clk[i]  = bus_q;
      assign mod_clk[i]  = mod_q;
   end

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
   import pds_pkg::*;
#(
   parameter int unsigned N_DOM       = 2,
   parameter int unsigned DW          = (N_DOM > 1) ? $clog2(N_DOM) : 1,
   parameter int unsigned STEP_DLY    = 4,
   parameter logic [N_DOM-1:0] ISO_PRESENT = 2'b01,
   parameter logic [N_DOM-1:0] RST_PRESENT = 2'b11,
   parameter logic [N_DOM-1:0] LATE_UP     = 2'b10,
   parameter logic [N_DOM-1:0] INIT_OFF    = 2'b10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_up,
   input  logic [DW-1:0]    cmd_dom,
   output logic [N_DOM-1:0] pwr_off,
   output logic [N_DOM-1:0] iso_n,
   output logic [N_DOM-1:0] dom_rst_n,
   output logic [N_DOM-1:0] repair_stb,
   output logic [N_DOM-1:0] sram_clk_stb,
   output logic [N_DOM-1:0] bus_clk_stb,
   output logic [N_DOM-1:0] mod_clk_stb,
   output logic [N_DOM-1:0] dom_on,
   output logic             busy,
   output logic             done,
   output logic             cmd_err
);

   if (N_DOM < 2) begin : g_bad_ndom
      $error("pwr_dom_seq: N_DOM must be at least 2");
   end
   if (STEP_DLY < 1) begin : g_bad_dly
      $error("pwr_dom_seq: STEP_DLY must be at least 1");
   end
   if ((1 << DW) < N_DOM) begin : g_bad_dw
      $error("pwr_dom_seq: DW too narrow for N_DOM");
   end

   logic          fire;
   pds_act_e      act;
   logic [DW-1:0] act_dom;

   pds_sequencer #(
      .N_DOM(N_DOM), .DW(DW), .STEP_DLY(STEP_DLY),
      .ISO_PRESENT(ISO_PRESENT), .RST_PRESENT(RST_PRESENT), .LATE_UP(LATE_UP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_up(cmd_up), .cmd_dom(cmd_dom),
      .busy(busy), .done(done), .err(cmd_err),
      .fire(fire), .act(act), .act_dom(act_dom)
   );

   pds_dom_bank #(
      .N_DOM(N_DOM), .DW(DW),
      .ISO_PRESENT(ISO_PRESENT), .RST_PRESENT(RST_PRESENT), .INIT_OFF(INIT_OFF)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .fire(fire), .act(act), .act_dom(act_dom),
      .pwr_off(pwr_off), .iso_n(iso_n), .rst_n_o(dom_rst_n),
      .repair(repair_stb), .sram_clk(sram_clk_stb),
      .bus_clk(bus_clk_stb), .mod_clk(mod_clk_stb)
   );

   assign dom_on = ~pwr_off;

endmodule

// File: rtl/pds_chk.sv
module pds_chk #(
   parameter int unsigned N_DOM       = 2,
   parameter logic [N_DOM-1:0] ISO_PRESENT = '1,
   parameter logic [N_DOM-1:0] RST_PRESENT = '1,
   parameter logic [N_DOM-1:0] LATE_UP     = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             busy,
   input logic             done,
   input logic             cmd_err,
   input logic [N_DOM-1:0] pwr_off,
   input logic [N_DOM-1:0] iso_n,
   input logic [N_DOM-1:0] dom_rst_n,
   input logic [N_DOM-1:0] repair_stb,
   input logic [N_DOM-1:0] sram_clk_stb,
   input logic [N_DOM-1:0] bus_clk_stb,
   input logic [N_DOM-1:0] mod_clk_stb
);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8
   reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && busy) |=> cmd_err);

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);

   for (genvar i = 0; i < N_DOM; i++) begin : g_d
      // R4
      strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({repair_stb[i], sram_clk_stb[i], bus_clk_stb[i], mod_clk_stb[i]}));

      // R3
      rst_rel_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(dom_rst_n[i]) |-> !pwr_off[i]);

      // R3
      iso_rel_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(iso_n[i]) |-> !pwr_off[i]);

      if (RST_PRESENT[i]) begin : g_rst
         // R2
         pwr_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwr_off[i]) |-> !dom_rst_n[i]);
         if (LATE_UP[i]) begin : g_late
            // R4
            late_iso_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
               $rose(iso_n[i]) |-> !dom_rst_n[i]);
         end else begin : g_legacy
            // R3
            legacy_iso_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
               $rose(iso_n[i]) |-> dom_rst_n[i]);
         end
      end

      if (ISO_PRESENT[i]) begin : g_iso
         // R2
         pwr_after_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwr_off[i]) |-> !iso_n[i]);
         // R2
         rst_after_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(dom_rst_n[i]) |-> !iso_n[i]);
      end else begin : g_noiso
         // R6
         iso_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            iso_n[i]);
      end
   end

endmodule

bind pwr_dom_seq pds_chk #(
   .N_DOM(N_DOM), .ISO_PRESENT(ISO_PRESENT),
   .RST_PRESENT(RST_PRESENT), .LATE_UP(LATE_UP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
   .busy(busy), .done(done), .cmd_err(cmd_err),
   .pwr_off(pwr_off), .iso_n(iso_n), .dom_rst_n(dom_rst_n),
   .repair_stb(repair_stb), .sram_clk_stb(sram_clk_stb),
   .bus_clk_stb(bus_clk_stb), .mod_clk_stb(mod_clk_stb)
);

// File: tb/tb_pwr_dom_seq.sv
`timescale 1ns/100ps
module tb_pwr_dom_seq;

   localparam int D = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_up = 1'b0;
   logic [0:0] cmd_dom = '0;
   logic [1:0] pwr_off, iso_n, dom_rst_n, repair_stb, sram_clk_stb;
   logic [1:0] bus_clk_stb, mod_clk_stb, dom_on;
   logic       busy, done, cmd_err;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pwr_dom_seq dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_up(cmd_up), .cmd_dom(cmd_dom),
      .pwr_off(pwr_off), .iso_n(iso_n), .dom_rst_n(dom_rst_n),
      .repair_stb(repair_stb), .sram_clk_stb(sram_clk_stb),
      .bus_clk_stb(bus_clk_stb), .mod_clk_stb(mod_clk_stb),
      .dom_on(dom_on), .busy(busy), .done(done), .cmd_err(cmd_err)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic adv(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Drive a one-cycle command; returns just after the accepting edge.
   task automatic issue(input logic up, input logic dom);
      cmd_valid = 1'b1;
      cmd_up    = up;
      cmd_dom   = dom;
      adv(1);
      cmd_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "pwr_off", 32'(pwr_off), 32'h2);
      chk("R1", "iso_n", 32'(iso_n), 32'h3);
      chk("R1", "dom_rst_n", 32'(dom_rst_n), 32'h1);
      chk("R1", "busy/done/err", {29'd0, busy, done, cmd_err}, 32'h0);
      chk("R9", "dom_on", 32'(dom_on), 32'h1);
   endtask

   task automatic t_down_dom0;
      issue(1'b0, 1'b0);
      chk("R7", "busy after accept", 32'(busy), 32'h1);
      chk("R5", "iso0 before first step", 32'(iso_n[0]), 32'h1);
      adv(1);
      chk("R2", "iso0 cleared first", {30'd0, iso_n[0], dom_rst_n[0]}, 32'h1);
      chk("R2", "pwr0 still on", 32'(pwr_off[0]), 32'h0);
      adv(D - 1);
      chk("R5", "rst0 held until interval ends", 32'(dom_rst_n[0]), 32'h1);
      adv(1);
      chk("R2", "rst0 cleared second", 32'(dom_rst_n[0]), 32'h0);
      chk("R2", "pwr0 not yet off", 32'(pwr_off[0]), 32'h0);
      adv(D);
      chk("R2", "pwr0 off last", 32'(pwr_off[0]), 32'h1);
      chk("R7", "busy low/done high", {30'd0, busy, done}, 32'h1);
      chk("R9", "dom_on0 off", 32'(dom_on[0]), 32'h0);
      chk("R2", "dom1 untouched", {29'd0, pwr_off[1], iso_n[1], dom_rst_n[1]}, 32'h6);
      adv(1);
      chk("R7", "done one cycle", 32'(done), 32'h0);
   endtask

   task automatic t_up_dom0_with_reject;
      issue(1'b1, 1'b0);
      adv(1);
      chk("R3", "pwr0 on first", {29'd0, pwr_off[0], dom_rst_n[0], iso_n[0]}, 32'h0);
      // extra command while busy: dom1 up
      cmd_valid = 1'b1; cmd_up = 1'b1; cmd_dom = 1'b1;
      adv(1);
      cmd_valid = 1'b0;
      chk("R8", "err set on reject", 32'(cmd_err), 32'h1);
      adv(D - 1);
      chk("R3", "rst0 released second", {30'd0, dom_rst_n[0], iso_n[0]}, 32'h2);
      adv(D);
      chk("R3", "iso0 released last", 32'(iso_n[0]), 32'h1);
      chk("R7", "done after up", {30'd0, busy, done}, 32'h1);
      chk("R8", "rejected dom1 unchanged", {29'd0, pwr_off[1], dom_rst_n[1], repair_stb[1]}, 32'h4);
      adv(1);
      chk("R8", "err sticky", 32'(cmd_err), 32'h1);
      chk("R8", "dom1 still off after idle", 32'(pwr_off[1]), 32'h1);
   endtask

   task automatic t_up_dom1_late;
      int bad_stb = 0;
      int bad_rst = 0;
      int bad_busy = 0;
      issue(1'b1, 1'b1);
      for (int t = 1; t <= 5 * D + 2; t++) begin
         logic [3:0] exp_stb;
         adv(1);
         exp_stb = {t == 4 * D + 2, t == 3 * D + 2, t == 2 * D + 2, t == D + 2};
         if ({mod_clk_stb[1], bus_clk_stb[1], sram_clk_stb[1], repair_stb[1]} !== exp_stb) bad_stb++;
         if (dom_rst_n[1] !== (t >= 5 * D + 2)) bad_rst++;
         if (busy !== (t < 5 * D + 2)) bad_busy++;
         if (t == 1) chk("R4", "pwr1 on first", 32'(pwr_off[1]), 32'h0);
         if (t == D + 1) chk("R6", "absent iso step drives nothing", {30'd0, iso_n[1], repair_stb[1]}, 32'h2);
         if (t == D + 2) chk("R6", "repair one cycle after skip", 32'(repair_stb[1]), 32'h1);
      end
      chk("R4", "strobe timing mismatches", 32'(bad_stb), 32'h0);
      chk("R4", "reset released last mismatches", 32'(bad_rst), 32'h0);
      chk("R7", "busy span mismatches", 32'(bad_busy), 32'h0);
      chk("R7", "done after late up", 32'(done), 32'h1);
      chk("R2", "dom0 untouched", {29'd0, pwr_off[0], iso_n[0], dom_rst_n[0]}, 32'h3);
      chk("R9", "dom_on both", 32'(dom_on), 32'h3);
      adv(1);
      chk("R4", "no strobe after end", {28'd0, mod_clk_stb[1], bus_clk_stb[1], sram_clk_stb[1], repair_stb[1]}, 32'h0);
   endtask

   task automatic t_down_dom1;
      issue(1'b0, 1'b1);
      adv(1);
      chk("R6", "skip step leaves lines", {29'd0, pwr_off[1], iso_n[1], dom_rst_n[1]}, 32'h3);
      adv(1);
      chk("R6", "rst1 one cycle after skip", 32'(dom_rst_n[1]), 32'h0);
      adv(D - 1);
      chk("R5", "pwr1 waits interval", 32'(pwr_off[1]), 32'h0);
      adv(1);
      chk("R2", "pwr1 off last", 32'(pwr_off[1]), 32'h1);
      chk("R7", "done after down1", 32'(done), 32'h1);
   endtask

   initial begin
      adv(3);
      rst_n = 1'b1;
      adv(1);
      t_reset();
      t_down_dom0();
      t_up_dom0_with_reject();
      t_up_dom1_late();
      t_down_dom1();
      adv(2);
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule